// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address into a physical one using a small on-chip table of segment descriptors. A logical address has two fields, a segment number and an offset within that segment. Each descriptor holds the segment's physical start address, its highest legal offset, and a resident flag. A separate segment-count register sets how many segment numbers the running process owns. A segment number at or above that count is rejected.

Software fills the descriptors and the segment-count register through a one-cycle write port. A translation request returns a registered response one cycle later. The response carries either the physical address, formed by adding the offset to the segment's start address, or a fault with a 2-bit cause code. When more than one check fails, only the highest-priority cause is reported. A request that arrives in the same cycle as a table write is dropped.

Top module: `seg_xlate`

## Requirements
- R1: While reset is asserted, and after it is released, every descriptor is not resident, the segment count is 0 and `rsp_valid` is low. A request made right after reset therefore faults with cause 1.
- R2: A request accepted in cycle N (`req_valid` high and `wr_en` low) produces `rsp_valid` high for exactly cycle N+1. There is no response in a cycle that follows no accepted request.
- R3: A request presented while `wr_en` is high is ignored. No response follows it, and the write completes normally.
- R4: If the segment number is greater than or equal to the segment count, the response faults with cause 1. This cause takes priority over every other check.
- R5: If the segment number is in range but the selected descriptor is not resident, the response faults with cause 2. This cause takes priority over the offset check.
- R6: If the offset is greater than the descriptor's limit, the response faults with cause 3. An offset equal to the limit is legal.
- R7: A request that passes all checks returns `rsp_fault` = 0, cause 0, and `rsp_paddr` = (base + offset) modulo 2^PA_W. The address is formed by addition, not by concatenation.
- R8: A write with `wr_sel` = 0 stores base, limit and resident flag into descriptor `wr_idx`. A write with `wr_sel` = 1 stores `wr_count` into the segment-count register. Either write affects requests accepted from the next cycle onward.
- R9: A faulted response drives `rsp_paddr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | Write target: 0 = descriptor, 1 = segment-count register |
| wr_idx | input | SEG_W | Descriptor to write |
| wr_base | input | PA_W | Physical start address for the descriptor |
| wr_limit | input | OFF_W | Highest legal offset for the descriptor |
| wr_resident | input | 1 | Resident flag for the descriptor |
| wr_count | input | SEG_W+1 | New segment count |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | SEG_W | Segment number of the request |
| req_off | input | OFF_W | Offset of the request |
| rsp_valid | output | 1 | One-cycle pulse marking a response |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cause | output | 2 | 0 ok, 1 segment out of range, 2 not resident, 3 offset beyond limit |
| rsp_paddr | output | PA_W | Physical address, or 0 on fault |

## Verification
The assertions assume that the inputs are held at zero while reset is asserted. The same assumption covers the cycles in which the internal reset is still being released. The stimulus therefore waits several idle cycles after reset before it drives anything. The assertions also assume that the bounds check compares the full offset against a limit of the same width, so that an offset equal to the limit is legal. The bench changes its inputs only on the falling edge. It exercises each fault cause both on its own and in combination with lower-priority faults. It also places writes in the same cycle as requests and directly before them.

// File: rtl/segx_pkg.sv
package segx_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_RANGE  = 2'd1,
    CAUSE_ABSENT = 2'd2,
    CAUSE_BOUND  = 2'd3
  } cause_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W-1:0] wr_limit,
  input  logic             wr_resident,
  input  logic [SEG_W:0]   wr_count,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [OFF_W-1:0] rd_limit,
  output logic             rd_resident,
  output logic [SEG_W:0]   count_q
);
  localparam int ENTRIES = 1 << SEG_W;

  logic [PA_W-1:0]  base_q  [ENTRIES];
  logic [OFF_W-1:0] limit_q [ENTRIES];
  logic [ENTRIES-1:0] res_q;
  logic [ENTRIES-1:0] ent_we;
  logic               count_we;
  logic [SEG_W:0]     count_d;

  always_comb begin
    count_we = wr_en && wr_sel;
    count_d  = count_we ? wr_count : count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [PA_W-1:0]  base_d;
    logic [OFF_W-1:0] limit_d;
    logic             res_d;

    always_comb begin
      ent_we[i] = wr_en && !wr_sel && (wr_idx == SEG_W'(i));
      base_d    = ent_we[i] ? wr_base     : base_q[i];
      limit_d   = ent_we[i] ? wr_limit    : limit_q[i];
      res_d     = ent_we[i] ? wr_resident : res_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        res_q[i]   <= 1'b0;
      end else begin
        base_q[i]  <= base_d;
        limit_q[i] <= limit_d;
        res_q[i]   <= res_d;
      end
    end
  end

  always_comb begin
    rd_base     = base_q[rd_idx];
    rd_limit    = limit_q[rd_idx];
    rd_resident = res_q[rd_idx];
  end

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && wr_sel) |-> $stable(count_q)) else $error("count changed without write"); // R8
  AST_RES_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(res_q)) else $error("resident flags changed without write"); // R8
endmodule

// File: rtl/seg_check.sv
module seg_check
  import segx_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  logic [SEG_W:0]   count,
  input  logic [PA_W-1:0]  base,
  input  logic [OFF_W-1:0] limit,
  input  logic             resident,
  output logic             fault,
  output cause_e           cause,
  output logic [PA_W-1:0]  paddr
);
  localparam int PAD_W = PA_W - OFF_W;

  logic out_of_range;
  logic absent;
  logic beyond;
  logic [PA_W-1:0] off_ext;

  always_comb begin
    out_of_range = {1'b0, seg} >= count;
    absent       = !resident;
    beyond       = off > limit;
    off_ext      = {{PAD_W{1'b0}}, off};
    if (out_of_range)  cause = CAUSE_RANGE;
    else if (absent)   cause = CAUSE_ABSENT;
    else if (beyond)   cause = CAUSE_BOUND;
    else               cause = CAUSE_NONE;
    fault = (cause != CAUSE_NONE);
    paddr = fault ? '0 : (base + off_ext);
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import segx_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W-1:0] wr_limit,
  input  logic             wr_resident,
  input  logic [SEG_W:0]   wr_count,
  input  logic             req_valid,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr
);
  logic sync1_q, rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      rst_ns  <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      rst_ns  <= sync1_q;
    end
  end

  logic [PA_W-1:0]  t_base;
  logic [OFF_W-1:0] t_limit;
  logic             t_res;
  logic [SEG_W:0]   count_q;

  seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
    .clk(clk), .rst_n(rst_ns),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_resident(wr_resident),
    .wr_count(wr_count), .rd_idx(req_seg),
    .rd_base(t_base), .rd_limit(t_limit), .rd_resident(t_res),
    .count_q(count_q)
  );

  logic            c_fault;
  cause_e          c_cause;
  logic [PA_W-1:0] c_paddr;

  seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .seg(req_seg), .off(req_off), .count(count_q),
    .base(t_base), .limit(t_limit), .resident(t_res),
    .fault(c_fault), .cause(c_cause), .paddr(c_paddr)
  );

  logic            accept;
  logic            v_d, f_d;
  logic [1:0]      c_d;
  logic [PA_W-1:0] a_d;

  always_comb begin
    accept = req_valid && !wr_en;
    v_d    = accept;
    f_d    = accept ? c_fault : rsp_fault;
    c_d    = accept ? c_cause : rsp_cause;
    a_d    = accept ? c_paddr : rsp_paddr;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'd0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= v_d;
      rsp_fault <= f_d;
      rsp_cause <= c_d;
      rsp_paddr <= a_d;
    end
  end

  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid |-> $past(req_valid && !wr_en)) else $error("response without request"); // R2
  AST_WR_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(wr_en) |-> !rsp_valid) else $error("request during write answered"); // R3
  AST_RANGE_WINS: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(req_valid && !wr_en && ({1'b0, req_seg} >= count_q)) |-> (rsp_cause == 2'd1)) else $error("range fault not first"); // R4
  AST_ABSENT_BEFORE_BOUND: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(req_valid && !wr_en && ({1'b0, req_seg} < count_q) && !t_res) |-> (rsp_cause == 2'd2)) else $error("absent fault lost"); // R5
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_ns)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)) else $error("fault with address"); // R9
  AST_CAUSE_AGREES: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0))) else $error("fault flag and cause disagree"); // R7
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  localparam int SEG_W = 3;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;
  localparam int ENT   = 1 << SEG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, wr_resident = 0, req_valid = 0;
  logic [SEG_W-1:0] wr_idx = '0, req_seg = '0;
  logic [PA_W-1:0]  wr_base = '0;
  logic [OFF_W-1:0] wr_limit = '0, req_off = '0;
  logic [SEG_W:0]   wr_count = '0;
  logic             rsp_valid, rsp_fault;
  logic [1:0]       rsp_cause;
  logic [PA_W-1:0]  rsp_paddr;

  always #10 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_resident(wr_resident),
    .wr_count(wr_count), .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit    active = 0;

  // reference model
  int m_base [ENT];
  int m_lim  [ENT];
  bit m_res  [ENT];
  int m_count;
  bit e_v, e_f;
  int e_c, e_a;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) begin m_base[i] = 0; m_lim[i] = 0; m_res[i] = 0; end
      m_count = 0; e_v = 0; e_f = 0; e_c = 0; e_a = 0;
    end else begin
      e_v = req_valid && !wr_en;
      if (e_v) begin
        int s, o;
        s = int'(req_seg); o = int'(req_off);
        if (s >= m_count)        e_c = 1;
        else if (!m_res[s])      e_c = 2;
        else if (o > m_lim[s])   e_c = 3;
        else                     e_c = 0;
        e_f = (e_c != 0);
        e_a = e_f ? 0 : ((m_base[s] + o) % (1 << PA_W));
      end
      if (wr_en && wr_sel) m_count = int'(wr_count);
      if (wr_en && !wr_sel) begin
        m_base[wr_idx] = int'(wr_base);
        m_lim[wr_idx]  = int'(wr_limit);
        m_res[wr_idx]  = wr_resident;
      end
    end
  end

  always @(negedge clk) begin
    if (active) begin
      checks++;
      if (rsp_valid !== e_v) begin
        errors++;
        $display("FAIL %s rsp_valid actual %0b expected %0b", tag, rsp_valid, e_v);
      end else if (e_v && (rsp_fault !== e_f || int'(rsp_cause) != e_c || int'(rsp_paddr) != e_a)) begin
        errors++;
        $display("FAIL %s fault/cause/paddr actual %0b/%0d/%h expected %0b/%0d/%h",
                 tag, rsp_fault, rsp_cause, rsp_paddr, e_f, e_c, e_a);
      end
    end
  end

  task automatic idle();
    wr_en = 0; req_valid = 0;
    @(negedge clk);
  endtask

  task automatic wr_ent(input int idx, input int base, input int lim, input bit res);
    wr_en = 1; wr_sel = 0; wr_idx = SEG_W'(idx); wr_base = PA_W'(base);
    wr_limit = OFF_W'(lim); wr_resident = res; req_valid = 0;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_cnt(input int n);
    wr_en = 1; wr_sel = 1; wr_count = (SEG_W+1)'(n); req_valid = 0;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rq(input int s, input int o);
    req_valid = 1; req_seg = SEG_W'(s); req_off = OFF_W'(o); wr_en = 0;
    @(negedge clk); req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    active = 1;
    tag = "R1"; idle(); idle();
    rq(0, 0); rq(7, 5); idle();             // R1: count 0 -> range fault
    tag = "R8"; wr_ent(0, 'h1000, 'h0FF, 1); wr_ent(1, 'hFFF0, 'h040, 1);
    wr_ent(2, 'h3000, 'h010, 0); wr_ent(5, 'h5000, 'hFFF, 1); wr_cnt(4);
    tag = "R7"; rq(0, 'h020); rq(1, 'h020); idle();   // R7 wrap
    tag = "R6"; rq(0, 'h0FF); rq(0, 'h100); idle();   // R6 equal ok, one past faults
    tag = "R5"; rq(2, 'h000); rq(2, 'h800); rq(3, 0); idle(); // R5
    tag = "R4"; rq(5, 0); rq(6, 'hFFF); idle();        // R4 resident but out of range
    tag = "R9"; rq(0, 'hFFF); idle();                  // R9
    tag = "R3";                                        // R3 request with write
    wr_en = 1; wr_sel = 0; wr_idx = 3; wr_base = 'h7000; wr_limit = 'h00F; wr_resident = 1;
    req_valid = 1; req_seg = 0; req_off = 1;
    @(negedge clk); wr_en = 0; req_valid = 0;
    idle(); rq(3, 'h00F);
    tag = "R8"; wr_cnt(6); rq(5, 'h123);             // R8 takes effect next cycle
    wr_ent(5, 'h0200, 'h010, 1); rq(5, 'h011);
    tag = "R2"; rq(0, 1); rq(1, 2); rq(3, 3); idle(); idle(); // R2 back-to-back
    tag = "R2";
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) begin
        wr_en = 1; wr_sel = $urandom_range(0, 1); wr_idx = SEG_W'($urandom);
        wr_base = PA_W'($urandom); wr_limit = OFF_W'($urandom); wr_resident = $urandom_range(0, 1);
        wr_count = (SEG_W+1)'($urandom_range(0, 8));
      end else wr_en = 0;
      req_valid = ($urandom_range(0, 3) != 0);
      req_seg = SEG_W'($urandom); req_off = OFF_W'($urandom_range(0, 300));
      @(negedge clk);
    end
    idle(); idle();
    active = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule